// File: doc/BRIEF.md
# Multi-Mode Serial Test Pattern Generator

This block produces a serial bit stream for exercising and stressing data links. It emits one bit per enabled clock strobe. The stream is one of several maximal-length pseudorandom sequences, a zero-limited pseudorandom stream, a 32-bit repeating pattern, or two 16-bit words that alternate after a programmable number of word periods. Every mode takes its data from one shared 32-bit pattern input, and the meaning of that input depends on the mode.

Channel and time-slot selection is done outside the block. Only the resulting strobe reaches `bit_en_i`. Software selects a mode, loads the pattern input and pulses `reload_i` to restart the stream from a known point.

Top module: `link_pattern_gen`

## Requirements
- R1: After reset, the pseudorandom register holds all ones and the bit index, word counter, word select and zero-run count are all zero. In mode 0 the first output is therefore 1 without any reload, and a stream started without a reload follows the all-ones seed.
- R2: Modes 0, 1, 2 and 3 are Fibonacci shift registers of length L = 7, 9, 11 and 15, with tap stage T = 6, 5, 9 and 14. The output is stage L (bit L-1). On each step the register shifts toward the output and stage 1 takes stage L XOR stage T. A reload seeds the register from `pattern_i[L-1:0]`.
- R3: In mode 0 with an all-ones seed, the stream repeats with a period of 127 bits, and its first seven bits are ones.
- R4: Mode 4 is a 20-stage register with tap stage 17, using the same construction as R2. Its output is forced to 1 whenever the previous 14 output bits were all 0, so no run of zeros is longer than 14. The forcing does not alter the register.
- R5: Mode 5 sends `pattern_i` from bit 0 up to bit 31 and then wraps back to bit 0.
- R6: Mode 6 sends word A (`pattern_i[15:0]`) and word B (`pattern_i[31:16]`), each least significant bit first. Each word is repeated `alt_count_i`+1 times before the block switches to the other word, so codes 0 to 255 give 1 to 256 words.
- R7: While `bit_en_i` is low and `reload_i` is low, the generator state holds and the output bit does not change.
- R8: A reload reseeds the pseudorandom register, clears the bit index, the word counter and the zero-run count, and selects word A. A reload wins over a simultaneous enable strobe.
- R9: Mode code 7 is idle, and in that mode the output is constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pattern_i | input | 32 | Shared pattern and seed value |
| mode_i | input | 3 | Mode code: 0 to 3 PRBS7/9/11/15, 4 zero-limited PRBS20, 5 repeat, 6 alternating, 7 idle |
| alt_count_i | input | 8 | Words per alternation minus one |
| bit_en_i | input | 1 | Advance strobe, one bit per high cycle |
| reload_i | input | 1 | Restart from the pattern input |
| data_o | output | 1 | Serial pattern bit |

## Verification
Some properties are checked by assertions on every cycle. These are: the register holds when there is no strobe and no reload, a nonzero pseudorandom state never collapses to zero, the zero-run count stays at or below 14, a reload clears the word sequencer, and the word select changes only at a word boundary. The bench scenarios cover what the assertions cannot see. These are the exact bit sequences of each mode, the 127-bit period, the forced one after fourteen zeros, the 256-word alternation limit, reload priority in mid-stream and the idle mode.

// File: rtl/link_pattern_pkg.sv
package link_pattern_pkg;
  typedef enum logic [2:0] {
    MODE_PRBS7  = 3'd0,
    MODE_PRBS9  = 3'd1,
    MODE_PRBS11 = 3'd2,
    MODE_PRBS15 = 3'd3,
    MODE_QRSS   = 3'd4,
    MODE_REPEAT = 3'd5,
    MODE_ALT    = 3'd6,
    MODE_IDLE   = 3'd7
  } lpg_mode_e;

  localparam int LFSR_W    = 20;
  localparam int ZRUN_MAX  = 14;
  localparam int WORD_W    = 16;
endpackage

// File: rtl/lpg_lfsr.sv
module lpg_lfsr
  import link_pattern_pkg::*;
#(
  parameter int W = LFSR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [2:0]   cfg_i,
  input  logic [W-1:0] seed_i,
  output logic         raw_o
);
  localparam int NCFG = 8;
  localparam int NLEN = 5;
  localparam int LEN [NLEN] = '{7, 9, 11, 15, 20};
  localparam int TAP [NLEN] = '{6, 5, 9, 14, 17};

  logic [W-1:0] sr;
  logic [NCFG-1:0] fb_v, out_v;
  logic [W-1:0] mask_v [NCFG];
  logic [W-1:0] mask_cur;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    if (g < NLEN) begin : g_len
      assign fb_v[g]   = sr[LEN[g]-1] ^ sr[TAP[g]-1];
      assign out_v[g]  = sr[LEN[g]-1];
      assign mask_v[g] = W'((64'd1 << LEN[g]) - 64'd1);
    end else begin : g_none
      assign fb_v[g]   = 1'b0;
      assign out_v[g]  = 1'b0;
      assign mask_v[g] = '0;
    end
  end

  assign mask_cur = mask_v[cfg_i];
  assign raw_o    = out_v[cfg_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr <= '1;
    else if (load_i) sr <= seed_i & mask_cur;
    else if (en_i)   sr <= {sr[W-2:0], fb_v[cfg_i]} & mask_cur;
  end

  // R7
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(sr));

  // R2
  lfsr_lockup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && cfg_i < 3'd5 && (sr & mask_cur) != '0 |=> sr != '0);
endmodule

// File: rtl/lpg_zero_limit.sv
module lpg_zero_limit
  import link_pattern_pkg::*;
#(
  parameter int MAX_RUN = ZRUN_MAX
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic raw_i,
  output logic data_o
);
  localparam int CW = $clog2(MAX_RUN + 1);

  logic [CW-1:0] zcnt;

  assign data_o = raw_i | (zcnt == CW'(MAX_RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     zcnt <= '0;
    else if (clr_i)  zcnt <= '0;
    else if (en_i)   zcnt <= data_o ? '0 : zcnt + 1'b1;
  end

  // R4
  zrun_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zcnt <= CW'(MAX_RUN));
endmodule

// File: rtl/lpg_word_seq.sv
module lpg_word_seq
  import link_pattern_pkg::*;
#(
  parameter int PW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             alt_i,
  input  logic [PW-1:0]    pattern_i,
  input  logic [CNT_W-1:0] alt_cnt_i,
  output logic             data_o
);
  localparam int IDX_W = $clog2(PW);
  localparam int BIT_W = $clog2(WORD_W);

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] wcnt;
  logic             sel;
  logic             word_end;

  assign word_end = (idx[BIT_W-1:0] == '1);
  // word B sits directly above word A
  assign data_o = alt_i ? pattern_i[{sel, idx[BIT_W-1:0]}] : pattern_i[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx  <= '0;
      wcnt <= '0;
      sel  <= 1'b0;
    end else if (clr_i) begin
      idx  <= '0;
      wcnt <= '0;
      sel  <= 1'b0;
    end else if (en_i) begin
      idx <= idx + 1'b1;
      if (alt_i && word_end) begin
        if (wcnt == alt_cnt_i) begin
          wcnt <= '0;
          sel  <= ~sel;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  // R8
  word_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> idx == '0 && wcnt == '0 && !sel);

  // R6
  word_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel) |-> idx[BIT_W-1:0] == '0);
endmodule

// File: rtl/link_pattern_gen.sv
module link_pattern_gen
  import link_pattern_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] alt_count_i,
  input  logic             bit_en_i,
  input  logic             reload_i,
  output logic             data_o
);
  lpg_mode_e mode;
  logic      is_prng, is_qrss, is_word, is_alt;
  logic      raw_bit, lim_bit, word_bit;

  assign mode    = lpg_mode_e'(mode_i);
  assign is_prng = (mode_i <= 3'(MODE_QRSS));
  assign is_qrss = (mode == MODE_QRSS);
  assign is_alt  = (mode == MODE_ALT);
  assign is_word = (mode == MODE_REPEAT) || is_alt;

  lpg_lfsr #(.W(LFSR_W)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bit_en_i && is_prng),
    .load_i (reload_i),
    .cfg_i  (mode_i),
    .seed_i (pattern_i[LFSR_W-1:0]),
    .raw_o  (raw_bit)
  );

  lpg_zero_limit #(.MAX_RUN(ZRUN_MAX)) i_zlim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bit_en_i && is_qrss),
    .clr_i  (reload_i),
    .raw_i  (raw_bit),
    .data_o (lim_bit)
  );

  lpg_word_seq #(.PW(PAT_W), .CNT_W(CNT_W)) i_wseq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (bit_en_i && is_word),
    .clr_i     (reload_i),
    .alt_i     (is_alt),
    .pattern_i (pattern_i),
    .alt_cnt_i (alt_count_i),
    .data_o    (word_bit)
  );

  always_comb begin
    unique case (mode)
      MODE_PRBS7, MODE_PRBS9, MODE_PRBS11, MODE_PRBS15: data_o = raw_bit;
      MODE_QRSS:                  data_o = lim_bit;
      MODE_REPEAT, MODE_ALT:      data_o = word_bit;
      default:                    data_o = 1'b0;
    endcase
  end
endmodule

// File: tb/test_link_pattern_gen.sv
module test_link_pattern_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 11;
  localparam int  OBS_N = 512;

  typedef struct packed {
    logic [2:0]  mode;
    logic [31:0] pat;
    logic [7:0]  alt;
    logic [15:0] nbits;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 32'hFFFF_FFFF, 8'd0,  16'd300},
    '{3'd1, 32'hFFFF_FFFF, 8'd0,  16'd600},
    '{3'd2, 32'hFFFF_FFFF, 8'd0,  16'd300},
    '{3'd3, 32'hFFFF_FFFF, 8'd0,  16'd300},
    '{3'd4, 32'h0000_0001, 8'd0,  16'd400},
    '{3'd4, 32'hFFFF_FFFF, 8'd0,  16'd300},
    '{3'd5, 32'h5AD6_B5AD, 8'd0,  16'd80},
    '{3'd5, 32'h8000_0001, 8'd0,  16'd70},
    '{3'd6, 32'h7E7E_0000, 8'd49, 16'd1700},
    '{3'd6, 32'hA5A5_3C3C, 8'd0,  16'd100},
    '{3'd6, 32'hFFFF_0000, 8'd2,  16'd120}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pattern_i = '0;
  logic [2:0]  mode_i = '0;
  logic [7:0]  alt_count_i = '0;
  logic        bit_en_i = 1'b0;
  logic        reload_i = 1'b0;
  logic        data_o;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  logic [19:0] m_sr;
  logic [4:0]  m_idx;
  logic [7:0]  m_wc;
  logic        m_sel;
  int          m_z;
  logic        obs [OBS_N];
  int          first_one;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  link_pattern_gen i_link_pattern_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pattern_i   (pattern_i),
    .mode_i      (mode_i),
    .alt_count_i (alt_count_i),
    .bit_en_i    (bit_en_i),
    .reload_i    (reload_i),
    .data_o      (data_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] md);
    case (md)
      3'd0: return 7;
      3'd1: return 9;
      3'd2: return 11;
      3'd3: return 15;
      default: return 20;
    endcase
  endfunction

  function automatic int tap_of(input logic [2:0] md);
    case (md)
      3'd0: return 6;
      3'd1: return 5;
      3'd2: return 9;
      3'd3: return 14;
      default: return 17;
    endcase
  endfunction

  function automatic logic [19:0] mask_of(input logic [2:0] md);
    logic [31:0] m;
    m = (32'd1 << len_of(md)) - 32'd1;
    return m[19:0];
  endfunction

  function automatic string tag_of(input logic [2:0] md);
    if (md <= 3'd3) return "R2";
    if (md == 3'd4) return "R4";
    if (md == 3'd5) return "R5";
    if (md == 3'd6) return "R6";
    return "R9";
  endfunction

  function automatic logic ref_bit();
    logic b;
    if (mode_i <= 3'd4) begin
      b = m_sr[len_of(mode_i)-1];
      if (mode_i == 3'd4 && m_z >= 14) b = 1'b1;
    end else if (mode_i == 3'd5) begin
      b = pattern_i[m_idx];
    end else if (mode_i == 3'd6) begin
      b = m_sel ? pattern_i[16 + int'(m_idx[3:0])] : pattern_i[m_idx[3:0]];
    end else begin
      b = 1'b0;
    end
    return b;
  endfunction

  task automatic ref_adv();
    logic b, fb;
    b = ref_bit();
    if (mode_i <= 3'd4) begin
      fb   = m_sr[len_of(mode_i)-1] ^ m_sr[tap_of(mode_i)-1];
      m_sr = {m_sr[18:0], fb} & mask_of(mode_i);
      if (mode_i == 3'd4) m_z = b ? 0 : m_z + 1;
    end else if (mode_i == 3'd5 || mode_i == 3'd6) begin
      if (mode_i == 3'd6 && m_idx[3:0] == 4'hF) begin
        if (m_wc == alt_count_i) begin
          m_wc  = '0;
          m_sel = ~m_sel;
        end else begin
          m_wc = m_wc + 1'b1;
        end
      end
      m_idx = m_idx + 1'b1;
    end
  endtask

  task automatic ref_reload();
    m_sr  = pattern_i[19:0] & mask_of(mode_i);
    m_idx = '0;
    m_wc  = '0;
    m_sel = 1'b0;
    m_z   = 0;
  endtask

  // compare n bits against the reference; gapped drops the strobe every other cycle
  task automatic step(input int n, input bit gapped, output int nerr,
                      output int bad_i, output logic act, output logic exp);
    logic e, en;
    nerr = 0; bad_i = -1; act = 1'b0; exp = 1'b0; first_one = -1;
    for (int i = 0; i < n; i++) begin
      e = ref_bit();
      if (i < OBS_N) obs[i] = data_o;
      if (data_o === 1'b1 && first_one < 0) first_one = i;
      if (data_o !== e) begin
        if (nerr == 0) begin bad_i = i; act = data_o; exp = e; end
        nerr++;
      end
      en = gapped ? (i % 2 == 0) : 1'b1;
      bit_en_i = en;
      @(negedge clk_i);
      if (en) ref_adv();
    end
    bit_en_i = 1'b0;
  endtask

  task automatic start(input logic [2:0] md, input logic [31:0] pt, input logic [7:0] al);
    @(negedge clk_i);
    mode_i = md; pattern_i = pt; alt_count_i = al;
    reload_i = 1'b1; bit_en_i = 1'b0;
    ref_reload();
    @(negedge clk_i);
    reload_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int ne, bi;
    logic a, x;
    bit ok;

    // R1 reset state
    mode_i = 3'd0; pattern_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    check(data_o === 1'b1, "R1", "output during reset", data_o, 1);
    rst_ni = 1'b1;
    m_sr = '1; m_idx = '0; m_wc = '0; m_sel = 1'b0; m_z = 0;
    @(negedge clk_i);
    step(40, 1'b0, ne, bi, a, x);
    check(ne == 0, "R1", $sformatf("stream from reset seed bit %0d", bi), a, x);

    // table of modes and patterns
    for (int v = 0; v < NVEC; v++) begin
      start(VECS[v].mode, VECS[v].pat, VECS[v].alt);
      step(int'(VECS[v].nbits), 1'b0, ne, bi, a, x);
      check(ne == 0, tag_of(VECS[v].mode),
            $sformatf("vector %0d bit %0d", v, bi), a, x);
      if (v == 0) begin
        // R3 period of 127 and leading ones
        ok = 1'b1;
        for (int i = 0; i < 7; i++) if (obs[i] !== 1'b1) ok = 1'b0;
        for (int i = 0; i < 150; i++) if (obs[i] !== obs[i+127]) ok = 1'b0;
        for (int p = 1; p < 127; p++) begin
          bit same;
          same = 1'b1;
          for (int i = 0; i < 127; i++) if (obs[i] !== obs[i+p]) same = 1'b0;
          if (same) ok = 1'b0;
        end
        check(ok, "R3", "prbs7 period", ok, 1);
      end
      if (v == 4) begin
        // R4 forced one after 14 zeros
        ok = 1'b1;
        for (int i = 0; i < 14; i++) if (obs[i] !== 1'b0) ok = 1'b0;
        check(ok && obs[14] === 1'b1, "R4", "forced one position",
              first_one, 14);
      end
      if (v == 8) begin
        // R6 50 words of A (zero) then B starting 0,1
        check(first_one == 801, "R6", "first one after 50 words", first_one, 801);
      end
    end

    // R6 upper limit: 256 words
    start(3'd6, 32'hFFFF_0000, 8'd255);
    step(4100, 1'b0, ne, bi, a, x);
    check(first_one == 4096, "R6", "first one with count code 255", first_one, 4096);

    // R7 hold without strobe, then gapped strobe
    start(3'd3, 32'hFFFF_FFFF, 8'd0);
    step(50, 1'b0, ne, bi, a, x);
    x = ref_bit();
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (data_o !== x) ok = 1'b0;
      @(negedge clk_i);
    end
    check(ok, "R7", "output held while strobe low", data_o, x);
    step(60, 1'b1, ne, bi, a, x);
    check(ne == 0, "R7", $sformatf("gapped strobe bit %0d", bi), a, x);

    // R8 reload beats enable, mid-stream in prbs9 and alternating mode
    start(3'd1, 32'hFFFF_FFFF, 8'd0);
    step(33, 1'b0, ne, bi, a, x);
    reload_i = 1'b1; bit_en_i = 1'b1; ref_reload();
    @(negedge clk_i);
    reload_i = 1'b0; bit_en_i = 1'b0;
    step(40, 1'b0, ne, bi, a, x);
    check(ne == 0 && obs[0] === 1'b1, "R8", $sformatf("prbs reload bit %0d", bi), a, x);
    start(3'd6, 32'h0F0F_00FF, 8'd0);
    step(21, 1'b0, ne, bi, a, x);
    reload_i = 1'b1; bit_en_i = 1'b1; ref_reload();
    @(negedge clk_i);
    reload_i = 1'b0; bit_en_i = 1'b0;
    step(64, 1'b0, ne, bi, a, x);
    check(ne == 0, "R8", $sformatf("word reload bit %0d", bi), a, x);

    // R9 idle code
    start(3'd7, 32'hFFFF_FFFF, 8'd0);
    ok = 1'b1;
    bit_en_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (data_o !== 1'b0) ok = 1'b0;
      @(negedge clk_i);
    end
    bit_en_i = 1'b0;
    check(ok, "R9", "idle mode output", data_o, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule